// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Router

This block decides which of N interrupt targets receive an inter-processor interrupt. Software first writes the high command word, which holds the 8-bit destination. It then writes the low command word, which holds the vector, the delivery mode, the addressing mode, the assert and trigger bits and the shorthand field. The low-word write starts the routing.

The router compares the command against each target's ID, logical-destination and format words, its presence bit and the index of the sending target. One cycle after the low-word write it presents a registered delivery mask with a one-cycle valid strobe, together with the vector and mode fields that the per-target request logic needs.

In lowest-priority mode the matching targets are not all served. One winner is picked by a round-robin pointer kept for each vector, so that repeated interrupts on one vector rotate across the eligible targets.

Top module: `ipi_router`

## Requirements
- R1: With shorthand 1 (low word bits [19:18]), only the sender (`sender_i`) is selected, provided it is present.
- R2: Shorthand 2 selects every present target. Shorthand 3 selects every present target except the sender.
- R3: With shorthand 0 and physical addressing (low word bit 11 = 0), a present target matches when bits [31:24] of its ID word equal the destination byte, which is bits [31:24] of the stored high word.
- R4: With shorthand 0 and logical addressing (bit 11 = 1), a target whose format word has bits [31:28] = 4'hF (flat) matches when its logical byte (LDR bits [31:24]) ANDed with the destination is nonzero.
- R5: For a target in cluster format (format bits [31:28] not 4'hF), logical matching requires equal low nibbles of the logical byte and the destination, and a nonzero AND of their high nibbles.
- R6: In lowest-priority mode (bits [10:8] = 3'b001) with logical addressing, exactly one target is granted. It is the first matching target after the vector's stored pointer, searching upward and wrapping around. That vector's pointer becomes the winner. Pointers are kept per vector and start at 0.
- R7: Lowest-priority mode with physical addressing, or with no matching target, produces an all-zero mask while still pulsing valid.
- R8: Lowest-priority mode with logical addressing, shorthand 0 and destination 8'hFF, while any present target is in cluster format, raises `lp_err_o`, produces a zero mask and leaves the pointer unchanged.
- R9: Targets whose presence bit is 0 never appear in the mask, and the round-robin search skips them.
- R10: `dlv_valid_o` is high for exactly the one cycle after a low-word write. The mask and fields are registered at that write.
- R11: The low word reads back as written, except that bit 12 always reads 0. The high word reads back with only bits [31:24] kept.
- R12: After reset, valid, mask, error and both readback words are zero.
- R13: `dlv_vector_o`, `dlv_mode_o`, `dlv_assert_o` and `dlv_level_o` carry low word bits [7:0], [10:8], 14 and 15 of the write that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_lo_wr_i | input | 1 | Write strobe for the low command word; starts routing |
| cmd_lo_i | input | 32 | Low command word data |
| cmd_hi_wr_i | input | 1 | Write strobe for the high command word |
| cmd_hi_i | input | 32 | High command word data (destination in [31:24]) |
| sender_i | input | SIDX_W | Index of the sending target |
| tgt_present_i | input | N | Presence bit for each target slot |
| tgt_id_i | input | N*32 | ID words, one per target, ID in [31:24] |
| tgt_ldr_i | input | N*32 | Logical-destination words, logical byte in [31:24] |
| tgt_fmt_i | input | N*32 | Format words, flat when [31:28] = 4'hF |
| cmd_lo_rd_o | output | 32 | Low command word readback |
| cmd_hi_rd_o | output | 32 | High command word readback |
| dlv_valid_o | output | 1 | One-cycle result strobe |
| dlv_mask_o | output | N | Delivery mask |
| dlv_vector_o | output | 8 | Vector of the routed command |
| dlv_mode_o | output | 3 | Delivery mode of the routed command |
| dlv_assert_o | output | 1 | Assert bit of the routed command |
| dlv_level_o | output | 1 | Trigger-mode bit of the routed command |
| lp_err_o | output | 1 | Lowest-priority cluster broadcast error |

## Verification
The hardest state to reach from the ports is the round-robin pointer of one vector sitting just before a hole in the presence map. Only a chain of earlier lowest-priority commands on that same vector puts it there. The stimulus issues several lowest-priority broadcasts on one vector to walk its pointer step by step. It then clears a presence bit and checks that the next grant jumps past the hole. A second vector is then used to show that its pointer still starts from zero. A scoreboard model keeps its own pointer per vector, so every grant in the chain is predicted without reference to the design.

// File: rtl/ipi_router_pkg.sv
`timescale 1ns/1ps
package ipi_router_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXT    = 3'd7
  } dlv_mode_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    shorthand_e sh;
    logic       level;
    logic       asrt;
    logic       logical;
    dlv_mode_e  mode;
    logic [7:0] vector;
  } cmd_t;

  localparam int unsigned STATUS_BIT = 12;

  function automatic cmd_t decode_cmd(input logic [31:0] w);
    cmd_t c;
    c.vector  = w[7:0];
    c.mode    = dlv_mode_e'(w[10:8]);
    c.logical = w[11];
    c.asrt    = w[14];
    c.level   = w[15];
    c.sh      = shorthand_e'(w[19:18]);
    return c;
  endfunction

endpackage

// File: rtl/ipi_dest_match.sv
`timescale 1ns/1ps
module ipi_dest_match
  import ipi_router_pkg::*;
(
  input  shorthand_e  sh_i,
  input  logic        logical_i,
  input  logic [7:0]  dest_i,
  input  logic [7:0]  id_i,
  input  logic [7:0]  ldr_i,
  input  logic        flat_i,
  input  logic        present_i,
  input  logic        is_sender_i,
  output logic        hit_o
);

  logic flat_hit, cluster_hit, addr_hit;

  assign flat_hit    = |(ldr_i & dest_i);
  assign cluster_hit = (ldr_i[3:0] == dest_i[3:0]) && |(ldr_i[7:4] & dest_i[7:4]);

  always_comb begin
    if (logical_i) addr_hit = flat_i ? flat_hit : cluster_hit;
    else           addr_hit = (id_i == dest_i);
  end

  always_comb begin
    unique case (sh_i)
      SH_NONE:   hit_o = present_i & addr_hit;
      SH_SELF:   hit_o = present_i & is_sender_i;
      SH_ALL:    hit_o = present_i;
      SH_OTHERS: hit_o = present_i & ~is_sender_i;
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_rr_arb.sv
`timescale 1ns/1ps
module ipi_rr_arb #(
  parameter int unsigned N     = 8,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             en_i,
  output logic [N-1:0]     grant_o,
  output logic             any_o
);

  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned VECS  = 1 << VEC_W;

  logic [IDX_W-1:0] ptr_q [VECS];
  logic [IDX_W-1:0] ptr_cur, win;

  assign ptr_cur = ptr_q[vec_i];

  // cyclic search starting one slot past the pointer; pointer slot checked last
  always_comb begin
    grant_o = '0;
    any_o   = 1'b0;
    win     = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int idx;
      idx = int'(ptr_cur) + k;
      if (idx >= int'(N)) idx = idx - int'(N);
      if (!any_o && req_i[idx]) begin
        grant_o[idx] = 1'b1;
        any_o        = 1'b1;
        win          = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int v = 0; v < int'(VECS); v++) ptr_q[v] <= '0;
    end else if (en_i && any_o) begin
      ptr_q[vec_i] <= win;
    end
  end

  assert_grant_in_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & ~req_i) == '0) && $onehot0(grant_o) && (any_o == |req_i));

endmodule

// File: rtl/ipi_router.sv
`timescale 1ns/1ps
module ipi_router
  import ipi_router_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned SIDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_lo_wr_i,
  input  logic [31:0]       cmd_lo_i,
  input  logic              cmd_hi_wr_i,
  input  logic [31:0]       cmd_hi_i,
  input  logic [SIDX_W-1:0] sender_i,
  input  logic [N-1:0]      tgt_present_i,
  input  logic [N*32-1:0]   tgt_id_i,
  input  logic [N*32-1:0]   tgt_ldr_i,
  input  logic [N*32-1:0]   tgt_fmt_i,
  output logic [31:0]       cmd_lo_rd_o,
  output logic [31:0]       cmd_hi_rd_o,
  output logic              dlv_valid_o,
  output logic [N-1:0]      dlv_mask_o,
  output logic [7:0]        dlv_vector_o,
  output logic [2:0]        dlv_mode_o,
  output logic              dlv_assert_o,
  output logic              dlv_level_o,
  output logic              lp_err_o
);

  cmd_t        cmd;
  logic [7:0]  dest;
  logic [N-1:0] hits, cluster_vec, grant, mask_d;
  logic        lowest, rr_any, err_d, rr_en;

  logic [31:0]  lo_q, hi_q;
  logic         valid_q, err_q, asrt_q, level_q;
  logic [N-1:0] mask_q;
  logic [7:0]   vec_q;
  logic [2:0]   mode_q;

  assign cmd  = decode_cmd(cmd_lo_i);
  assign dest = hi_q[31:24];

  for (genvar g = 0; g < int'(N); g++) begin : g_tgt
    logic flat;
    assign flat           = (tgt_fmt_i[g*32+28 +: 4] == 4'hF);
    assign cluster_vec[g] = tgt_present_i[g] & ~flat;
    ipi_dest_match i_match (
      .sh_i        (cmd.sh),
      .logical_i   (cmd.logical),
      .dest_i      (dest),
      .id_i        (tgt_id_i[g*32+24 +: 8]),
      .ldr_i       (tgt_ldr_i[g*32+24 +: 8]),
      .flat_i      (flat),
      .present_i   (tgt_present_i[g]),
      .is_sender_i (sender_i == SIDX_W'(g)),
      .hit_o       (hits[g])
    );
  end

  assign lowest = (cmd.mode == DM_LOWEST);
  assign err_d  = lowest && cmd.logical && (cmd.sh == SH_NONE) &&
                  (dest == 8'hFF) && |cluster_vec;
  assign rr_en  = cmd_lo_wr_i && lowest && cmd.logical && !err_d;

  ipi_rr_arb #(.N(N), .VEC_W(VEC_W)) i_rr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (hits),
    .vec_i   (cmd.vector[VEC_W-1:0]),
    .en_i    (rr_en),
    .grant_o (grant),
    .any_o   (rr_any)
  );

  always_comb begin
    if (!lowest)                        mask_d = hits;
    else if (cmd.logical && !err_d && rr_any) mask_d = grant;
    else                                mask_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      valid_q <= 1'b0;
      mask_q  <= '0;
      vec_q   <= '0;
      mode_q  <= '0;
      asrt_q  <= 1'b0;
      level_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= cmd_lo_wr_i;
      if (cmd_hi_wr_i) hi_q <= {cmd_hi_i[31:24], 24'h0};
      if (cmd_lo_wr_i) begin
        lo_q    <= cmd_lo_i & ~(32'h1 << STATUS_BIT);
        mask_q  <= mask_d;
        vec_q   <= cmd.vector;
        mode_q  <= cmd.mode;
        asrt_q  <= cmd.asrt;
        level_q <= cmd.level;
        err_q   <= err_d;
      end
    end
  end

  assign cmd_lo_rd_o  = lo_q;
  assign cmd_hi_rd_o  = hi_q;
  assign dlv_valid_o  = valid_q;
  assign dlv_mask_o   = mask_q;
  assign dlv_vector_o = vec_q;
  assign dlv_mode_o   = mode_q;
  assign dlv_assert_o = asrt_q;
  assign dlv_level_o  = level_q;
  assign lp_err_o     = err_q;

  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_lo_wr_i |=> !dlv_valid_o);

  assert_lowest_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o && dlv_mode_o == DM_LOWEST) |-> $onehot0(dlv_mask_o));

  assert_present_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dlv_valid_o) |-> ((dlv_mask_o & ~$past(tgt_present_i)) == '0));

  assert_others_skip_sender_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_lo_wr_i && cmd.sh == SH_OTHERS) |=> !dlv_mask_o[$past(sender_i)]);

  assert_err_no_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o && lp_err_o) |-> (dlv_mask_o == '0));

endmodule

// File: tb/test_ipi_router.sv
`timescale 1ns/1ps
module test_ipi_router;

  localparam int N = 8;

  typedef struct {
    logic [N-1:0] mask;
    bit           err;
    logic [7:0]   vec;
    logic [2:0]   mode;
    bit           asrt;
    bit           level;
    string        req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lo_wr = 1'b0, hi_wr = 1'b0;
  logic [31:0]   lo_d = '0, hi_d = '0;
  logic [2:0]    snd = '0;
  logic [N-1:0]  pres = '1;
  logic [31:0]   id_r [N], ldr_r [N], fmt_r [N];
  logic [N*32-1:0] id_f, ldr_f, fmt_f;
  logic [31:0]   lo_rd, hi_rd;
  logic          vld, asrt_o, level_o, err_o;
  logic [N-1:0]  mask_o;
  logic [7:0]    vec_o;
  logic [2:0]    mode_o;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];
  int ptr_m [256];
  logic [7:0] dest_m = '0;

  always #4 clk = ~clk;

  always_comb
    for (int t = 0; t < N; t++) begin
      id_f[t*32 +: 32]  = id_r[t];
      ldr_f[t*32 +: 32] = ldr_r[t];
      fmt_f[t*32 +: 32] = fmt_r[t];
    end

  ipi_router #(.N(N)) i_ipi_router (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_lo_wr_i(lo_wr), .cmd_lo_i(lo_d),
    .cmd_hi_wr_i(hi_wr), .cmd_hi_i(hi_d),
    .sender_i(snd), .tgt_present_i(pres),
    .tgt_id_i(id_f), .tgt_ldr_i(ldr_f), .tgt_fmt_i(fmt_f),
    .cmd_lo_rd_o(lo_rd), .cmd_hi_rd_o(hi_rd),
    .dlv_valid_o(vld), .dlv_mask_o(mask_o), .dlv_vector_o(vec_o),
    .dlv_mode_o(mode_o), .dlv_assert_o(asrt_o), .dlv_level_o(level_o),
    .lp_err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent reference model
  function automatic exp_t predict(input logic [31:0] lo, input int s, input string req);
    exp_t e;
    logic [N-1:0] m;
    bit logical, lowest, anyclu;
    int sh;
    m = '0; anyclu = 0;
    logical = lo[11]; sh = int'(lo[19:18]); lowest = (lo[10:8] == 3'b001);
    for (int t = 0; t < N; t++) begin
      bit h;
      logic [7:0] lb;
      lb = ldr_r[t][31:24];
      if (pres[t] && fmt_r[t][31:28] != 4'hF) anyclu = 1;
      h = 0;
      if (sh == 1) h = (t == s);
      else if (sh == 2) h = 1;
      else if (sh == 3) h = (t != s);
      else if (!logical) h = (id_r[t][31:24] == dest_m);
      else if (fmt_r[t][31:28] == 4'hF) h = ((lb & dest_m) != 0);
      else h = (lb[3:0] == dest_m[3:0]) && ((lb[7:4] & dest_m[7:4]) != 0);
      m[t] = h && pres[t];
    end
    e.err = lowest && logical && sh == 0 && dest_m == 8'hFF && anyclu;
    if (lowest) begin
      logic [N-1:0] req_m;
      req_m = m; m = '0;
      if (logical && !e.err)
        for (int k = 1; k <= N; k++) begin
          int ix;
          ix = (ptr_m[lo[7:0]] + k) % N;
          if (req_m[ix]) begin
            m[ix] = 1'b1;
            ptr_m[lo[7:0]] = ix;
            break;
          end
        end
    end
    e.mask = m; e.vec = lo[7:0]; e.mode = lo[10:8];
    e.asrt = lo[14]; e.level = lo[15]; e.req = req;
    return e;
  endfunction

  function automatic logic [31:0] mk(input int sh, input bit lvl, input bit as,
                                     input bit logical, input int mode, input int vec);
    return (32'(sh) << 18) | (32'(lvl) << 15) | (32'(as) << 14) |
           (32'(logical) << 11) | (32'(mode) << 8) | 32'(vec & 8'hFF);
  endfunction

  task automatic set_dest(input logic [7:0] d);
    hi_d = {d, 24'h5A5A5A}; hi_wr = 1'b1;
    @(negedge clk); hi_wr = 1'b0; dest_m = d;
  endtask

  task automatic send(input logic [31:0] lo, input int s, input string req);
    q.push_back(predict(lo, s, req));
    lo_d = lo; snd = 3'(s); lo_wr = 1'b1;
    @(negedge clk); lo_wr = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare each result against the scoreboard
  always @(negedge clk) if (rst_n && vld) begin
    if (q.size() == 0) chk(0, "R10", "unexpected valid", 32'(vld), 32'h0);
    else begin
      exp_t e;
      e = q.pop_front();
      chk(mask_o == e.mask, e.req, "mask", 32'(mask_o), 32'(e.mask));
      chk(err_o == e.err, (e.err ? "R8" : e.req), "lp_err", 32'(err_o), 32'(e.err));
      chk(vec_o == e.vec && mode_o == e.mode && asrt_o == e.asrt && level_o == e.level,
          "R13", "fields", {16'h0, level_o, asrt_o, 3'b0, mode_o, vec_o},
          {16'h0, 1'(e.level), 1'(e.asrt), 3'b0, e.mode, e.vec});
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 256; v++) ptr_m[v] = 0;
    for (int t = 0; t < N; t++) begin
      id_r[t]  = {8'h20 + 8'(t), 24'h0};
      ldr_r[t] = {8'(1 << t), 24'h0};
      fmt_r[t] = 32'hFFFF_FFFF;
    end
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!vld && mask_o == 0 && !err_o, "R12", "outputs", {vld, err_o, 22'h0, mask_o}, 32'h0);
    chk(lo_rd == 0 && hi_rd == 0, "R12", "readback", lo_rd | hi_rd, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: readback masking
    set_dest(8'hAB);
    chk(hi_rd == 32'hAB00_0000, "R11", "hi readback", hi_rd, 32'hAB00_0000);
    send(mk(0, 1, 1, 0, 0, 8'h77) | 32'h1000, 0, "R3");
    chk(lo_rd == ((mk(0, 1, 1, 0, 0, 8'h77))), "R11", "lo readback bit12", lo_rd,
        mk(0, 1, 1, 0, 0, 8'h77));
    // R10: valid dropped after one cycle
    chk(!vld, "R10", "valid one cycle", 32'(vld), 32'h0);

    // R3: physical
    set_dest(8'h23);
    send(mk(0, 0, 1, 0, 0, 8'h31), 0, "R3");
    set_dest(8'h99);
    send(mk(0, 0, 1, 0, 4, 8'h32), 0, "R3");

    // R4: flat logical
    set_dest(8'h05);
    send(mk(0, 0, 1, 1, 0, 8'h33), 1, "R4");
    set_dest(8'hC0);
    send(mk(0, 1, 0, 1, 0, 8'h34), 1, "R4");

    // R1/R2: shorthands
    send(mk(1, 0, 1, 0, 0, 8'h35), 3, "R1");
    send(mk(2, 0, 1, 0, 0, 8'h36), 3, "R2");
    send(mk(3, 0, 1, 0, 0, 8'h37), 3, "R2");
    pres = 8'hEF;
    send(mk(2, 0, 1, 0, 0, 8'h38), 0, "R2");
    send(mk(1, 0, 1, 0, 0, 8'h39), 4, "R1");
    pres = 8'hFF;

    // R5: cluster logical
    for (int t = 0; t < N; t++) begin
      ldr_r[t] = {4'(1 << (t % 4)), 4'(t / 4), 24'h0};
      fmt_r[t] = 32'h0FFF_FFFF;
    end
    set_dest(8'h31);
    send(mk(0, 0, 1, 1, 0, 8'h3A), 0, "R5");
    set_dest(8'h30);
    send(mk(0, 0, 1, 1, 0, 8'h3B), 0, "R5");
    set_dest(8'h82);
    send(mk(0, 0, 1, 1, 0, 8'h3C), 0, "R5");

    // R8: cluster broadcast lowest-priority
    set_dest(8'hFF);
    send(mk(0, 0, 1, 1, 1, 8'h40), 0, "R8");

    // R6: round robin in flat mode
    for (int t = 0; t < N; t++) begin
      ldr_r[t] = {8'(1 << t), 24'h0};
      fmt_r[t] = 32'hFFFF_FFFF;
    end
    for (int i = 0; i < 10; i++) send(mk(0, 0, 1, 1, 1, 8'h40), 0, "R6");
    send(mk(0, 0, 1, 1, 1, 8'h41), 0, "R6");
    send(mk(2, 0, 1, 1, 1, 8'h41), 5, "R6");

    // R9: skip absent slots
    send(mk(0, 0, 1, 1, 1, 8'h50), 0, "R9");
    pres = 8'hFB;
    send(mk(0, 0, 1, 1, 1, 8'h50), 0, "R9");
    pres = 8'h7F;
    set_dest(8'h80);
    send(mk(0, 0, 1, 1, 1, 8'h51), 0, "R9");
    pres = 8'hFF;

    // R7: physical or empty lowest-priority
    set_dest(8'h22);
    send(mk(0, 0, 1, 0, 1, 8'h52), 0, "R7");
    set_dest(8'h00);
    send(mk(0, 0, 1, 1, 1, 8'h53), 0, "R7");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R10", "missing results", 32'(q.size()), 32'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule